// File: doc/BRIEF.md
# Priority Interrupt Controller with Mask Compare

This block arbitrates among a set of interrupt request lines and presents at most one request to a processor. Every source carries a 4-bit priority level, set through a flat level bus. Each source is also set up either to follow its line as a level or to capture rising edges into a sticky pending bit. The controller picks the highest-level pending source. Among sources of equal level, the lower source index wins. It raises a request to the processor only when that level is strictly above the processor's current 4-bit mask. With the request it gives a registered vector number, equal to a base offset plus the source index, and the level the processor loads into its mask.

An active-low accept pin tells logic outside the block that an interrupt has been accepted. For a level-sensed winner, the pin follows the request and is released as soon as the request is no longer accepted. For an edge-captured winner, the pin stays low until the processor's acknowledge pulse, which marks the start of exception entry. The acknowledge pulse also clears the captured edge of the acknowledged source. Software can cancel captured edges through a write-one-to-clear port, and it can read the captured edges on a status output.

Top module: `prio_intc`

## Requirements
- R1: While reset is low and after it: `cpu_req`=0, `accept_n`=1, `edge_stat`=0, `cpu_lvl`=0 and `cpu_vec`=VEC_BASE.
- R2: Among pending sources, the one with the highest level (`src_prio[4*i+3:4*i]` for source i) wins. `cpu_vec`=VEC_BASE+i and `cpu_lvl` is the winner's level. A higher-level request that arrives while another request is being presented replaces it.
- R3: When several pending sources share the top level, the lowest source index wins.
- R4: A request is raised only when the winner's level is strictly greater than `cpu_mask`. Equal or lower is not accepted, so a level-0 source is never accepted. A source that is not accepted stays pending.
- R5: A level-sensed source (`src_edge[i]`=0) reaches `cpu_req` one clock edge after its line is seen high. An edge-captured source (`src_edge[i]`=1) reaches `cpu_req` two edges after its rising edge: one edge to capture it, one edge to register the request.
- R6: A rising edge on an edge-captured source sets `edge_stat[i]`. The bit stays set, and the source stays pending, after the line falls, until it is acknowledged or cleared.
- R7: A clock with `clr_we`=1 clears every `edge_stat` bit whose `clr_bits` bit is 1 and leaves the others. A rising edge in the same clock wins over the clear.
- R8: `cpu_ack` while `cpu_req`=1 acknowledges the source shown in `cpu_vec`. It clears that source's captured edge and removes the source from arbitration in that clock. `cpu_ack` while `cpu_req`=0 leaves `edge_stat` unchanged.
- R9: With a level-sensed winner, `accept_n` is low exactly while `cpu_req` is 1.
- R10: Once an edge-captured source is accepted, `accept_n` stays low until the next `cpu_ack`. This holds even if software cancels the edge first.
- R11: If, in an acknowledge clock, another source's level still exceeds `cpu_mask`, `cpu_req` stays 1 with the new vector and `accept_n` stays low.
- R12: A level-sensed source is not captured. When its line falls, `cpu_req` drops one edge later and `accept_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears captured edges |
| src_req | input | N_SRC | Raw request lines |
| src_edge | input | N_SRC | Per source: 1 = capture rising edges, 0 = follow level |
| src_prio | input | 4*N_SRC | Per-source 4-bit priority levels, source i at bits 4*i+3:4*i |
| cpu_mask | input | 4 | Processor's current mask level |
| clr_we | input | 1 | Write strobe for cancelling captured edges |
| clr_bits | input | N_SRC | Write-one-to-clear pattern for captured edges |
| edge_stat | output | N_SRC | Captured edge status |
| cpu_ack | input | 1 | Single-cycle acknowledge at start of exception entry |
| cpu_req | output | 1 | Request to the processor |
| cpu_vec | output | VEC_W | Vector number of the presented request |
| cpu_lvl | output | 4 | Level of the presented request, to be loaded into the mask |
| accept_n | output | 1 | Active-low accept indicator |

## Verification
The bench checks ties at the top level (a design scanning from the high index would present source 6 instead of 3) and a level equal to the mask (a non-strict compare would raise a request). It cancels a captured edge in the same clock as a new rising edge; a design that lets the clear win would lose the interrupt. It acknowledges while another request is still above the mask, and cancels an accepted edge before any acknowledge. A design that drops the accept pin early, or keeps presenting the acknowledged source for one more cycle, shows the wrong vector or a high `accept_n`.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int LVL_W = 4;

  typedef logic [LVL_W-1:0] lvl_t;

  // A candidate replaces the current best only when strictly higher, so an
  // earlier (lower) index keeps a tie.
  function automatic logic lvl_beats(lvl_t cand, lvl_t best, logic have_best);
    return !have_best || (cand > best);
  endfunction

  // Acceptance needs a level strictly above the processor mask.
  function automatic logic lvl_accepted(lvl_t lvl, lvl_t mask);
    return lvl > mask;
  endfunction

  function automatic int unsigned vec_number(int unsigned base, int unsigned idx);
    return base + idx;
  endfunction

endpackage

// File: rtl/intc_edge_latch.sv
module intc_edge_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_req,
  input  logic [N-1:0] src_edge,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] ack_hit,
  output logic [N-1:0] latch_q
);

  logic [N-1:0] prev_q;
  logic [N-1:0] rise;
  logic [N-1:0] clear;

  assign rise  = src_req & ~prev_q & src_edge;
  assign clear = ({N{clr_we}} & clr_bits) | ack_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= src_req;
      latch_q <= (latch_q & ~clear) | rise;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_edge_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q[i] && !clear[i]) |=> latch_q[i]);
    assert_sw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_bits[i] && !rise[i]) |=> !latch_q[i]);
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit[i] && !rise[i]) |=> !latch_q[i]);
  end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]       pend,
  input  logic [N*LVL_W-1:0] prio_flat,
  output logic               win_valid,
  output logic [IW-1:0]      win_idx,
  output lvl_t               win_lvl
);

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && lvl_beats(prio_flat[i*LVL_W +: LVL_W], win_lvl, win_valid)) begin
        win_valid = 1'b1;
        win_idx   = IW'(i);
        win_lvl   = prio_flat[i*LVL_W +: LVL_W];
      end
    end
  end

endmodule

// File: rtl/intc_accept.sv
module intc_accept
  import intc_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int VW = 8,
  parameter int VB = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_valid,
  input  logic [IW-1:0] win_idx,
  input  lvl_t          win_lvl,
  input  logic          win_edge,
  input  lvl_t          cpu_mask,
  input  logic          cpu_ack,
  output logic          cpu_req,
  output logic [VW-1:0] cpu_vec,
  output lvl_t          cpu_lvl,
  output logic          accept_n,
  output logic          ack_valid,
  output logic [IW-1:0] ack_idx
);

  logic          accept_now;
  logic          req_q;
  logic          edge_q;
  logic          hold_q;
  logic [IW-1:0] idx_q;

  assign accept_now = win_valid && lvl_accepted(win_lvl, cpu_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      edge_q  <= 1'b0;
      idx_q   <= '0;
      cpu_vec <= VW'(VB);
      cpu_lvl <= '0;
    end else begin
      req_q <= accept_now;
      if (accept_now) begin
        edge_q  <= win_edge;
        idx_q   <= win_idx;
        cpu_vec <= VW'(vec_number(VB, int'(win_idx)));
        cpu_lvl <= win_lvl;
      end
    end
  end

  // Edge winners keep the pin low until the processor acknowledges entry.
  always_ff @(posedge clk) begin
    if (!rst_n)                       hold_q <= 1'b0;
    else if (accept_now && win_edge)  hold_q <= 1'b1;
    else if (cpu_ack)                 hold_q <= 1'b0;
  end

  assign cpu_req   = req_q;
  assign accept_n  = ~(req_q | hold_q);
  assign ack_valid = cpu_ack & req_q;
  assign ack_idx   = idx_q;

  assert_strict_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (cpu_lvl > $past(cpu_mask)));
  assert_edge_pin_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && edge_q && !cpu_ack) |=> !accept_n);
  assert_nested_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && accept_now) |=> (cpu_req && !accept_n));
  assert_vec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> ((int'(cpu_vec) >= VB) && (int'(cpu_vec) < VB + N)));

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       src_req,
  input  logic [N_SRC-1:0]       src_edge,
  input  logic [N_SRC*LVL_W-1:0] src_prio,
  input  logic [LVL_W-1:0]       cpu_mask,
  input  logic                   clr_we,
  input  logic [N_SRC-1:0]       clr_bits,
  output logic [N_SRC-1:0]       edge_stat,
  input  logic                   cpu_ack,
  output logic                   cpu_req,
  output logic [VEC_W-1:0]       cpu_vec,
  output logic [LVL_W-1:0]       cpu_lvl,
  output logic                   accept_n
);

  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] latch_q;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] pend_eff;
  logic [N_SRC-1:0] ack_hit;
  logic             ack_valid;
  logic [IDX_W-1:0] ack_idx;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl;
  logic             win_edge;

  intc_edge_latch #(.N(N_SRC)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_req  (src_req),
    .src_edge (src_edge),
    .clr_we   (clr_we),
    .clr_bits (clr_bits),
    .ack_hit  (ack_hit),
    .latch_q  (latch_q)
  );

  assign pend     = (src_edge & latch_q) | (~src_edge & src_req);
  assign ack_hit  = ack_valid ? ({{(N_SRC-1){1'b0}}, 1'b1} << ack_idx) : '0;
  assign pend_eff = pend & ~ack_hit;

  intc_arbiter #(.N(N_SRC), .IW(IDX_W)) u_arb (
    .pend      (pend_eff),
    .prio_flat (src_prio),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  assign win_edge = src_edge[win_idx];

  intc_accept #(.N(N_SRC), .IW(IDX_W), .VW(VEC_W), .VB(VEC_BASE)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl),
    .win_edge  (win_edge),
    .cpu_mask  (cpu_mask),
    .cpu_ack   (cpu_ack),
    .cpu_req   (cpu_req),
    .cpu_vec   (cpu_vec),
    .cpu_lvl   (cpu_lvl),
    .accept_n  (accept_n),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx)
  );

  assign edge_stat = latch_q;

  assert_winner_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> pend_eff[win_idx]);
  assert_ack_excluded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !(win_valid && (win_idx == ack_idx)));

endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;

  localparam int N = 8;
  localparam int VB = 64;

  // {req[27:20], mask[19:16], exp_req[15:12], exp_idx[11:8], exp_lvl[7:4], req_tag[3:0]}
  localparam logic [27:0] TBL [14] = '{
    {8'h01, 4'd0,  4'd1, 4'd0, 4'd3,  4'd2},  // R2 single source
    {8'h03, 4'd0,  4'd1, 4'd1, 4'd7,  4'd2},  // R2 higher level wins
    {8'h06, 4'd0,  4'd1, 4'd1, 4'd7,  4'd3},  // R3 tie at level 7
    {8'h04, 4'd0,  4'd1, 4'd2, 4'd7,  4'd2},  // R2
    {8'h48, 4'd0,  4'd1, 4'd3, 4'd12, 4'd3},  // R3 tie at level 12
    {8'h40, 4'd0,  4'd1, 4'd6, 4'd12, 4'd2},  // R2
    {8'h06, 4'd7,  4'd0, 4'd0, 4'd0,  4'd4},  // R4 equal to mask
    {8'h06, 4'd6,  4'd1, 4'd1, 4'd7,  4'd4},  // R4 one above mask
    {8'h20, 4'd0,  4'd0, 4'd0, 4'd0,  4'd4},  // R4 level zero
    {8'h91, 4'd4,  4'd1, 4'd7, 4'd5,  4'd2},  // R2
    {8'h91, 4'd5,  4'd0, 4'd0, 4'd0,  4'd4},  // R4
    {8'hFF, 4'd11, 4'd1, 4'd3, 4'd12, 4'd3},  // R3
    {8'hFF, 4'd12, 4'd0, 4'd0, 4'd0,  4'd4},  // R4
    {8'h00, 4'd0,  4'd0, 4'd0, 4'd0,  4'd12}  // R12 all withdrawn
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] src_req;
  logic [N-1:0] src_edge;
  logic [4*N-1:0] src_prio;
  logic [3:0]   cpu_mask;
  logic         clr_we;
  logic [N-1:0] clr_bits;
  logic [N-1:0] edge_stat;
  logic         cpu_ack;
  logic         cpu_req;
  logic [7:0]   cpu_vec;
  logic [3:0]   cpu_lvl;
  logic         accept_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_edge(src_edge),
    .src_prio(src_prio), .cpu_mask(cpu_mask), .clr_we(clr_we),
    .clr_bits(clr_bits), .edge_stat(edge_stat), .cpu_ack(cpu_ack),
    .cpu_req(cpu_req), .cpu_vec(cpu_vec), .cpu_lvl(cpu_lvl),
    .accept_n(accept_n)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Pulse an edge-captured line for one cycle.
  task automatic pulse_src(logic [N-1:0] bits);
    src_req = src_req | bits;
    nxt();
    src_req = src_req & ~bits;
  endtask

  task automatic ack_pulse();
    cpu_ack = 1'b1;
    nxt();
    cpu_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // levels: src0=3 src1=7 src2=7 src3=12 src4=1 src5=0 src6=12 src7=5
    src_prio = {4'd5, 4'd12, 4'd0, 4'd1, 4'd12, 4'd7, 4'd7, 4'd3};
    rst_n = 1'b0; src_req = '0; src_edge = '0; cpu_mask = '0;
    clr_we = 1'b0; clr_bits = '0; cpu_ack = 1'b0;
    repeat (3) nxt();
    chk("R1", "cpu_req in reset", 32'(cpu_req), 0);
    chk("R1", "accept_n in reset", 32'(accept_n), 1);
    chk("R1", "edge_stat in reset", 32'(edge_stat), 0);
    chk("R1", "cpu_lvl in reset", 32'(cpu_lvl), 0);
    chk("R1", "cpu_vec in reset", 32'(cpu_vec), VB);
    rst_n = 1'b1;
    nxt();
    chk("R1", "cpu_req after reset", 32'(cpu_req), 0);
    chk("R1", "accept_n after reset", 32'(accept_n), 1);

    // Table of level-sensed patterns
    for (int k = 0; k < 14; k++) begin
      logic [27:0] r;
      string tg;
      r = TBL[k];
      tg = $sformatf("R%0d/row%0d", r[3:0], k);
      src_req  = r[27:20];
      cpu_mask = r[19:16];
      nxt();
      chk(tg, "cpu_req", 32'(cpu_req), 32'(r[12]));
      chk(tg, "accept_n (R9)", 32'(accept_n), 32'(!r[12]));
      if (r[12]) begin
        chk(tg, "cpu_vec", 32'(cpu_vec), VB + r[11:8]);
        chk(tg, "cpu_lvl", 32'(cpu_lvl), 32'(r[7:4]));
      end
    end

    // R5 level latency: one edge
    cpu_mask = 4'd0;
    src_req = 8'h02;
    #1 chk("R5", "level req before edge", 32'(cpu_req), 0);
    @(posedge clk); #1;
    chk("R5", "level req after one edge", 32'(cpu_req), 1);
    nxt();
    src_req = '0;
    nxt();
    chk("R12", "level withdrawn req", 32'(cpu_req), 0);
    chk("R12", "level withdrawn accept_n", 32'(accept_n), 1);
    chk("R12", "level source not captured", 32'(edge_stat), 0);

    // R5/R6 edge latency and capture
    src_edge = 8'h80;
    src_req = 8'h80;
    @(posedge clk); #1;
    chk("R5", "edge req after one edge", 32'(cpu_req), 0);
    chk("R6", "edge captured", 32'(edge_stat), 32'h80);
    nxt();
    src_req = '0;
    @(posedge clk); #1;
    chk("R5", "edge req after two edges", 32'(cpu_req), 1);
    chk("R2", "edge vec", 32'(cpu_vec), VB + 7);
    repeat (3) nxt();
    chk("R6", "edge still pending", 32'(edge_stat), 32'h80);
    chk("R6", "edge req held", 32'(cpu_req), 1);
    chk("R10", "edge accept_n held low", 32'(accept_n), 0);

    // R8 acknowledge clears and releases
    cpu_mask = 4'd5;
    ack_pulse();
    chk("R8", "ack clears edge", 32'(edge_stat), 0);
    chk("R8", "req drops after ack", 32'(cpu_req), 0);
    chk("R10", "accept_n released at ack", 32'(accept_n), 1);

    // R4/R7 masked capture and software clear
    cpu_mask = 4'd15;
    src_edge = 8'h90;
    pulse_src(8'h90);
    nxt();
    chk("R4", "masked edges not requested", 32'(cpu_req), 0);
    chk("R6", "both edges captured", 32'(edge_stat), 32'h90);
    clr_we = 1'b1; clr_bits = 8'h10;
    nxt();
    clr_we = 1'b0; clr_bits = '0;
    chk("R7", "selective clear", 32'(edge_stat), 32'h80);
    src_req = 8'h10; clr_we = 1'b1; clr_bits = 8'h10;
    nxt();
    src_req = '0; clr_we = 1'b0; clr_bits = '0;
    chk("R7", "rise beats clear", 32'(edge_stat), 32'h90);
    ack_pulse();
    chk("R8", "ack without request ignored", 32'(edge_stat), 32'h90);
    clr_we = 1'b1; clr_bits = 8'h90;
    nxt();
    clr_we = 1'b0; clr_bits = '0;
    chk("R7", "clear all", 32'(edge_stat), 0);

    // R10 accept pin held across software cancel
    cpu_mask = 4'd0;
    src_edge = 8'h80;
    pulse_src(8'h80);
    nxt();
    chk("R10", "edge accepted", 32'(cpu_req), 1);
    clr_we = 1'b1; clr_bits = 8'h80;
    nxt();
    clr_we = 1'b0; clr_bits = '0;
    nxt();
    chk("R10", "req gone after cancel", 32'(cpu_req), 0);
    chk("R10", "accept_n still low after cancel", 32'(accept_n), 0);
    ack_pulse();
    chk("R10", "accept_n released by ack", 32'(accept_n), 1);

    // R11 nested acceptance at acknowledge
    pulse_src(8'h80);
    nxt();
    chk("R2", "edge source 7 presented", 32'(cpu_vec), VB + 7);
    src_req = 8'h08;
    nxt();
    chk("R2", "preempted by source 3", 32'(cpu_vec), VB + 3);
    chk("R2", "preempt level", 32'(cpu_lvl), 12);
    src_req = '0;
    ack_pulse();
    chk("R11", "req stays after ack", 32'(cpu_req), 1);
    chk("R11", "next vector", 32'(cpu_vec), VB + 7);
    chk("R11", "accept_n stays low", 32'(accept_n), 0);
    chk("R11", "edge of 7 kept", 32'(edge_stat), 32'h80);
    cpu_mask = 4'd5;
    ack_pulse();
    chk("R8", "final ack clears", 32'(edge_stat), 0);
    chk("R9", "final req low", 32'(cpu_req), 0);
    chk("R10", "final accept_n high", 32'(accept_n), 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule